// File: doc/BRIEF.md
# Count-Compare Interval Timer

This block keeps a free-running interval counter beside a compare register of the same width and raises a timer interrupt when the counter steps onto the compare value. The counter advances by one on every second clock while it runs. It wraps silently at the top of its range. Software reads both registers on plain output ports. It writes either register through a one-cycle write strobe with a register select.

The interrupt is sticky and stays high until software writes the compare register. To get periodic interrupts, the handler advances the compare value after each match. The block never reloads anything by itself. The interrupt output is meant to drive a timer-pending bit in a cause register kept elsewhere.

Counting can be frozen in two ways: by a count-disable input, or by debug mode when the debug freeze enable is also set. The register port has no back-pressure. A strobe is always accepted in the cycle it is presented, and it outranks any increment due in that cycle.

Top module: `cmpcnt_timer`

## Requirements
- R1: After reset the counter reads 0, the compare register reads all ones, and the interrupt is low.
- R2: While running, the counter increases by exactly one every second clock, and never on two consecutive clocks.
- R3: When an increment makes the counter equal to the compare value, the interrupt goes high at that same edge and stays high while the compare register is not written.
- R4: A write to the compare register (wr_sel = 1) clears the interrupt at that edge; a write to the counter (wr_sel = 0) leaves the interrupt unchanged.
- R5: A counter write loads the value at that edge, overriding any increment due there, and restarts the divide phase so the next increment lands two clocks after the write edge.
- R6: While cnt_halt is 1, the counter and its divide phase hold.
- R7: The counter holds while dbg_mode and dbg_freeze are both 1; either one alone has no effect on counting.
- R8: The counter wraps from 0xFFFFFFFF to 0, and a compare value of 0 matches on the wrapped value.
- R9: A compare write makes the new value visible on cmp_q at the next clock, and the counter is unaffected.
- R10: Writing the counter to a value equal to the compare register does not raise the interrupt; only an increment can.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 1 | 0 selects the counter, 1 the compare register |
| wr_data | input | 32 | Write value |
| cnt_halt | input | 1 | Count-disable control |
| dbg_mode | input | 1 | Core is in debug mode |
| dbg_freeze | input | 1 | Freeze counting while in debug mode |
| cnt_q | output | 32 | Current counter value |
| cmp_q | output | 32 | Current compare value |
| tmr_irq | output | 1 | Sticky timer interrupt |

## Verification
The bench uses the default parameters: a 32-bit counter and a divide ratio of two. The divide ratio gives a two-clock step, so an exact expected value can be computed for every clock. Because the counter is writable, loading values just below 0xFFFFFFFF brings the wrap and the match-on-zero case within a few clocks instead of billions. Random writes close to the running count land matches, write collisions and freezes in every phase of the divider.

// File: rtl/cmpcnt_pkg.sv
package cmpcnt_pkg;
  typedef enum logic {
    SEL_COUNT   = 1'b0,
    SEL_COMPARE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cmpcnt_prescale.sv
module cmpcnt_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] ph_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ph_q <= '0;
        else if (restart)    ph_q <= '0;
        else if (run)        ph_q <= (ph_q == LAST) ? '0 : ph_q + PW'(1);
      end

      assign tick = run && (ph_q == LAST);

      // R2: ticks are never on consecutive clocks
      a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      // R5: no tick in the clock right after a phase restart
      a_r5_restart_gap: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/cmpcnt_counter.sv
module cmpcnt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic         step,
  output logic [W-1:0] nxt
);
  assign step = tick && !wr;
  assign nxt  = cnt_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wr)   cnt_q <= wr_data;
    else if (step) cnt_q <= nxt;
  end

  // R2: without a write the counter either holds or moves up by one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + W'(1)));
  // R5: a written value always wins
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt_q == $past(wr_data));
  // R6: no tick and no write means no change
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/cmpcnt_match.sv
module cmpcnt_match #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_wr,
  input  logic [W-1:0] wr_data,
  input  logic         step,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] cmp_q,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_wr) cmp_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     irq <= 1'b0;
    else if (cmp_wr)                irq <= 1'b0;
    else if (step && nxt == cmp_q)  irq <= 1'b1;
  end

  // R3: the interrupt is sticky until a compare write
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cmp_wr) |=> irq);
  // R4: a compare write clears the interrupt
  a_r4_clear_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !irq);
  // R10: only an increment can raise the interrupt
  a_r10_set_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !step) |=> !irq);
endmodule

// File: rtl/cmpcnt_timer.sv
module cmpcnt_timer
  import cmpcnt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_halt,
  input  logic             dbg_mode,
  input  logic             dbg_freeze,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             tmr_irq
);
  reg_sel_e          sel;
  logic              cnt_wr, cmp_wr, run, tick, step;
  logic [CNT_W-1:0]  nxt;

  assign sel    = reg_sel_e'(wr_sel);
  assign cnt_wr = wr_en && (sel == SEL_COUNT);
  assign cmp_wr = wr_en && (sel == SEL_COMPARE);
  assign run    = !cnt_halt && !(dbg_mode && dbg_freeze);

  cmpcnt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(cnt_wr), .tick(tick)
  );

  cmpcnt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wr_data(wr_data),
    .tick(tick), .cnt_q(cnt_q), .step(step), .nxt(nxt)
  );

  cmpcnt_match #(.W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .wr_data(wr_data),
    .step(step), .nxt(nxt), .cmp_q(cmp_q), .irq(tmr_irq)
  );

  // R7: debug freeze holds the counter unless software writes it
  a_r7_debug_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && dbg_freeze && !cnt_wr) |=> $stable(cnt_q));
  // R9: a compare write does not disturb a frozen counter
  a_r9_cmp_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && cnt_halt) |=> $stable(cnt_q));
endmodule

// File: tb/cmpcnt_timer_bench.sv
`timescale 1ns/1ps
module cmpcnt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cnt_halt = 1'b0, dbg_mode = 1'b0, dbg_freeze = 1'b0;
  logic [31:0] cnt_q, cmp_q;
  logic        tmr_irq;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cmpcnt_timer u_cmpcnt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_halt(cnt_halt), .dbg_mode(dbg_mode), .dbg_freeze(dbg_freeze),
    .cnt_q(cnt_q), .cmp_q(cmp_q), .tmr_irq(tmr_irq)
  );

  // reference model built from the requirements
  logic [31:0] m_cnt, m_cmp;
  logic        m_irq, m_ph;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 32'h0; m_cmp <= 32'hFFFF_FFFF; m_irq <= 1'b0; m_ph <= 1'b0;
    end else begin
      logic running, inc, cw, mw;
      running = !cnt_halt && !(dbg_mode && dbg_freeze);
      cw  = wr_en && !wr_sel;
      mw  = wr_en && wr_sel;
      inc = running && m_ph && !cw;
      m_cnt <= cw ? wr_data : (inc ? m_cnt + 32'd1 : m_cnt);
      m_ph  <= cw ? 1'b0 : (running ? ~m_ph : m_ph);
      m_cmp <= mw ? wr_data : m_cmp;
      m_irq <= mw ? 1'b0 : ((inc && (m_cnt + 32'd1 == m_cmp)) ? 1'b1 : m_irq);
    end
  end

  function automatic logic [31:0] near(input logic [31:0] base);
    return base + ($urandom % 6);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] snap;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset count", cnt_q, 32'h0);
    chk("R1 reset compare", cmp_q, 32'hFFFF_FFFF);
    chk("R1 reset irq", {31'b0, tmr_irq}, 32'h0);

    // R9 / R5: load both registers and follow the step timing
    wr(1'b1, 32'd20);
    chk("R9 compare readback", cmp_q, 32'd20);
    wr(1'b0, 32'd10);
    chk("R5 count loaded", cnt_q, 32'd10);
    @(negedge clk); chk("R5 no step one clock after write", cnt_q, 32'd10);
    @(negedge clk); chk("R2 step two clocks after write", cnt_q, 32'd11);
    @(negedge clk); chk("R2 hold on odd clock", cnt_q, 32'd11);
    @(negedge clk); chk("R2 next step", cnt_q, 32'd12);

    // R3: match and stickiness
    while (cnt_q != 32'd19) @(negedge clk);
    chk("R3 irq low before match", {31'b0, tmr_irq}, 32'h0);
    @(negedge clk); @(negedge clk);
    chk("R3 count at compare", cnt_q, 32'd20);
    chk("R3 irq on match", {31'b0, tmr_irq}, 32'h1);
    repeat (10) @(negedge clk);
    chk("R3 irq sticky", {31'b0, tmr_irq}, 32'h1);

    // R4: count write keeps irq, compare write clears it
    wr(1'b0, 32'd5);
    chk("R4 irq kept after count write", {31'b0, tmr_irq}, 32'h1);
    chk("R4 count written", cnt_q, 32'd5);
    wr(1'b1, 32'd50);
    chk("R4 irq cleared by compare write", {31'b0, tmr_irq}, 32'h0);
    chk("R9 compare readback 2", cmp_q, 32'd50);

    // R6: disable freezes
    @(negedge clk); cnt_halt = 1'b1; snap = cnt_q;
    repeat (6) @(negedge clk);
    chk("R6 halted count", cnt_q, snap);
    wr(1'b1, 32'd400);
    chk("R9 compare write leaves halted count", cnt_q, snap);
    cnt_halt = 1'b0;

    // R7: debug freeze needs both controls
    dbg_mode = 1'b1; dbg_freeze = 1'b0; snap = cnt_q;
    repeat (4) @(negedge clk);
    chk("R7 debug mode alone counts", cnt_q, snap + 32'd2);
    dbg_freeze = 1'b1; snap = cnt_q;
    repeat (6) @(negedge clk);
    chk("R7 debug freeze holds", cnt_q, snap);
    dbg_mode = 1'b0; snap = cnt_q;
    repeat (4) @(negedge clk);
    chk("R7 freeze enable alone counts", cnt_q, snap + 32'd2);
    dbg_freeze = 1'b0;

    // R8: wrap and match on zero
    wr(1'b1, 32'h0);
    wr(1'b0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 top value held", cnt_q, 32'hFFFF_FFFF);
    chk("R8 no irq before wrap", {31'b0, tmr_irq}, 32'h0);
    @(negedge clk);
    chk("R8 wrapped to zero", cnt_q, 32'h0);
    chk("R8 match on wrapped value", {31'b0, tmr_irq}, 32'h1);

    // R10: writing count onto compare does not match
    wr(1'b1, 32'd100);
    wr(1'b0, 32'd100);
    chk("R10 no irq on equal write", {31'b0, tmr_irq}, 32'h0);
    @(negedge clk);
    chk("R10 still no irq", {31'b0, tmr_irq}, 32'h0);

    // random phase checked against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      chk("R2/R5 random count", cnt_q, m_cnt);
      chk("R9 random compare", cmp_q, m_cmp);
      chk("R3/R4 random irq", {31'b0, tmr_irq}, {31'b0, m_irq});
      wr_en = (($urandom % 10) == 0);
      wr_sel = $urandom % 2;
      case ($urandom % 3)
        0: wr_data = near(cnt_q);
        1: wr_data = 32'hFFFF_FFFC + ($urandom % 8);
        default: wr_data = $urandom;
      endcase
      cnt_halt = (($urandom % 20) == 0);
      if (($urandom % 16) == 0) dbg_mode = ~dbg_mode;
      if (($urandom % 16) == 0) dbg_freeze = ~dbg_freeze;
    end
    @(negedge clk);
    chk("R2 final count", cnt_q, m_cnt);
    finish_run();
  end
endmodule